// File: doc/BRIEF.md
# PPM Frame Capture Engine

This block turns the pulse-position-modulated output of a six-channel hobby radio transmitter into six pulse-width counts, each measured in clock cycles. The raw input arrives asynchronously. It passes through a two-flop synchronizer and then a stability filter: a new level is accepted only after it has held for a set number of consecutive cycles. The filtered level feeds a sequencer that first looks for the long idle high that separates frames. Only after it has seen an idle of sufficient length does it treat the following high pulses as channels 1 to 6.

The engine stays parked until a start input is seen while it is parked. It then locks onto one frame, stores the six widths, pulses a done flag and parks again. Software or a neighbouring block keeps the start input high to capture frame after frame.

Each store drives a one-cycle strobe together with a channel index, so a consumer can follow every update. The width registers themselves are also brought out. The strobe carries valid-only semantics with no ready: the radio stream cannot be stalled, so there is no back-pressure, and a consumer must take each strobe in the cycle it occurs.

Top module: `ppm_capture`

## Requirements
- R1: After reset all six width registers read 0, `wr_stb` and `frame_done` are low, and `state_probe` reads 0.
- R2: A high segment counts as the frame idle only if its filtered width is at least IDLE_CYC = CLK_HZ*IDLE_US/1e6 cycles. A width of exactly IDLE_CYC is accepted. A shorter one is discarded and the search for an idle starts again, so no channel is stored from the pulses that follow it.
- R3: The filtered level follows the synchronized input only after the input has differed from it for STABLE consecutive cycles. A glitch of STABLE-1 cycles, low inside a pulse or high inside a gap, has no effect on any stored width or on the strobe count.
- R4: The stored width of a channel equals the number of cycles its input pulse was high. The first high pulse after an accepted idle is channel index 0.
- R5: Each channel store raises `wr_stb` for exactly one cycle, with `wr_idx` counting 0,1,2,3,4,5 in frame order. The register `ch_width[wr_idx*CW +: CW]` holds the new width from the next cycle on.
- R6: `frame_done` is high for exactly one cycle per captured frame: the cycle of the store with index 5.
- R7: While parked (state 0) with `start` low, the input is ignored: no strobe occurs and the registers keep their values.
- R8: After the sixth store the engine parks. If `start` is high at that point, it resumes the idle search and captures the next frame, overwriting the registers.
- R9: The width counter saturates at 2^CW-1 instead of wrapping.
- R10: `state_probe` encodes the sequencer phase: 0 parked, 1 seeking a high, 2 timing the idle, 3 judging the idle, 4 awaiting a channel, 5 timing a channel, 6 storing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppm_raw | input | 1 | Asynchronous PPM line from the transmitter |
| start | input | 1 | Arms the engine while it is parked |
| ch_width | output | NCH*CW | Six width registers, channel k at bits k*CW +: CW |
| wr_stb | output | 1 | One-cycle store strobe |
| wr_idx | output | 3 | Channel index of the current store |
| frame_done | output | 1 | One-cycle flag on the last store of a frame |
| state_probe | output | 3 | Sequencer phase code |

## Verification
The bench builds the engine with CLK_HZ = 100000, so the idle threshold falls to 500 cycles and several full frames fit in a short run. Idles of 499 and exactly 500 cycles then probe both sides of the threshold. STABLE = 4 makes a 3-cycle glitch the largest one that must be rejected. CW = 10 brings saturation within reach, at a channel pulse of 1100 cycles.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [2:0] {
    PH_PARK     = 3'd0,
    PH_SEEK     = 3'd1,
    PH_IDLE_CNT = 3'd2,
    PH_IDLE_CHK = 3'd3,
    PH_CH_WAIT  = 3'd4,
    PH_CH_CNT   = 3'd5,
    PH_STORE    = 3'd6
  } phase_t;
endpackage

// File: rtl/ppm_in_cond.sv
module ppm_in_cond #(
  parameter int STABLE = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl
);
  localparam int SW = $clog2(STABLE + 1);

  logic          meta_q, sync_q;
  logic [SW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      lvl    <= 1'b0;
      run_q  <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      if (sync_q == lvl) begin
        run_q <= '0;
      end else if (run_q == SW'(STABLE - 1)) begin
        lvl   <= sync_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  generate
    if (STABLE >= 2) begin : g_chk
      // R3: a level change follows at least two cycles of agreeing input
      assert_settled_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl) |-> (lvl == $past(sync_q)) && (lvl == $past(sync_q, 2)));
    end
  endgenerate
endmodule

// File: rtl/ppm_width_ctr.sv
module ppm_width_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= CW'(1);
    else if (run && cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R9: counter never wraps
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (cnt >= $past(cnt)));
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/ppm_frame_seq.sv
module ppm_frame_seq
  import ppm_pkg::*;
#(
  parameter int          NCH      = 6,
  parameter int          CW       = 32,
  parameter logic [63:0] IDLE_CYC = 64'd500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lvl,
  input  logic                   start,
  input  logic [CW-1:0]          cnt,
  output logic                   cnt_load,
  output logic                   cnt_run,
  output logic                   wr_stb,
  output logic [$clog2(NCH)-1:0] wr_idx,
  output logic                   frame_done,
  output phase_t                 phase
);
  localparam int IW = $clog2(NCH);

  phase_t        nxt;
  logic [IW-1:0] chan_q;
  logic          last_ch, idle_ok;

  assign last_ch = (chan_q == IW'(NCH - 1));
  assign idle_ok = (64'(cnt) >= IDLE_CYC);
  assign wr_idx  = chan_q;

  always_comb begin
    nxt        = phase;
    cnt_load   = 1'b0;
    cnt_run    = 1'b0;
    wr_stb     = 1'b0;
    frame_done = 1'b0;
    case (phase)
      PH_PARK:     if (start) nxt = PH_SEEK;
      PH_SEEK:     if (lvl) begin cnt_load = 1'b1; nxt = PH_IDLE_CNT; end
      PH_IDLE_CNT: if (lvl) cnt_run = 1'b1; else nxt = PH_IDLE_CHK;
      PH_IDLE_CHK: nxt = idle_ok ? PH_CH_WAIT : PH_SEEK;
      PH_CH_WAIT:  if (lvl) begin cnt_load = 1'b1; nxt = PH_CH_CNT; end
      PH_CH_CNT:   if (lvl) cnt_run = 1'b1; else nxt = PH_STORE;
      PH_STORE: begin
        wr_stb = 1'b1;
        if (last_ch) begin frame_done = 1'b1; nxt = PH_PARK; end
        else         nxt = PH_CH_WAIT;
      end
      default:     nxt = PH_PARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_PARK;
      chan_q <= '0;
    end else begin
      phase <= nxt;
      if (phase == PH_IDLE_CHK) chan_q <= '0;
      else if (wr_stb)          chan_q <= last_ch ? '0 : chan_q + 1'b1;
    end
  end

  // R2: channel phase entered only from an idle of sufficient width
  assert_idle_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CH_WAIT && $past(phase) == PH_IDLE_CHK) |-> (64'($past(cnt)) >= IDLE_CYC));
  // R5: strobe lasts one cycle
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R6: done only with the last store
  assert_done_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (wr_stb && wr_idx == IW'(NCH - 1)));
  // R7: parked without start stays parked
  assert_park_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PARK && !start) |=> (phase == PH_PARK));
endmodule

// File: rtl/ppm_capture.sv
module ppm_capture
  import ppm_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int CW      = 32,
  parameter int STABLE  = 20,
  parameter int CLK_HZ  = 100_000_000,
  parameter int IDLE_US = 5000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ppm_raw,
  input  logic                   start,
  output logic [NCH*CW-1:0]      ch_width,
  output logic                   wr_stb,
  output logic [$clog2(NCH)-1:0] wr_idx,
  output logic                   frame_done,
  output logic [2:0]             state_probe
);
  localparam int          IW       = $clog2(NCH);
  localparam logic [63:0] IDLE_CYC = (64'(CLK_HZ) * 64'(IDLE_US)) / 64'd1_000_000;

  logic          lvl, cnt_load, cnt_run;
  logic [CW-1:0] cnt;
  phase_t        phase;
  logic [CW-1:0] wreg [NCH];

  ppm_in_cond #(.STABLE(STABLE)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(ppm_raw), .lvl(lvl));

  ppm_width_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .run(cnt_run), .cnt(cnt));

  ppm_frame_seq #(.NCH(NCH), .CW(CW), .IDLE_CYC(IDLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .start(start), .cnt(cnt),
    .cnt_load(cnt_load), .cnt_run(cnt_run), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .frame_done(frame_done), .phase(phase));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)                          wreg[g] <= '0;
        else if (wr_stb && wr_idx == IW'(g)) wreg[g] <= cnt;
      end
      assign ch_width[g*CW +: CW] = wreg[g];
    end
  endgenerate

  assign state_probe = phase;

  // R5: the addressed register takes the measured width
  assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (wreg[$past(wr_idx)] == $past(cnt)));
  // R7: registers change only on a strobe
  assert_regs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(ch_width));
endmodule

// File: tb/ppm_capture_tb.sv
module ppm_capture_tb;
  localparam int NCH = 6, CW = 10, STABLE = 4, CLK_HZ = 100_000, IDLE_US = 5000;
  localparam int IDLE = 500, GAP = 8, MAXW = 1023;

  logic clk = 1'b0, rst_n = 1'b0, ppm_raw = 1'b0, start = 1'b0;
  logic [NCH*CW-1:0] ch_width;
  logic wr_stb, frame_done;
  logic [2:0] wr_idx, state_probe;
  int checks = 0, errors = 0, stb_n = 0, done_n = 0, seq_bad = 0;

  ppm_capture #(.NCH(NCH), .CW(CW), .STABLE(STABLE), .CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .ppm_raw(ppm_raw), .start(start), .ch_width(ch_width),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .frame_done(frame_done), .state_probe(state_probe));

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin
      if (int'(wr_idx) != stb_n % NCH) seq_bad++;
      stb_n++;
    end
    if (frame_done) begin
      done_n++;
      if (!(wr_stb && wr_idx == 3'd5)) seq_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); ppm_raw = v; end
  endtask

  function automatic int wid(input int k);
    return int'(ch_width[k*CW +: CW]);
  endfunction

  task automatic frame(input int idle, input int w [NCH]);
    drive(1'b0, GAP); drive(1'b1, idle);
    for (int k = 0; k < NCH; k++) begin drive(1'b0, GAP); drive(1'b1, w[k]); end
    drive(1'b0, GAP); drive(1'b1, 20);
  endtask

  task automatic arm();
    @(negedge clk); start = 1'b1; repeat (2) @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_mon();
    stb_n = 0; done_n = 0; seq_bad = 0;
  endtask

  task automatic check_widths(input string tag, input int w [NCH]);
    for (int k = 0; k < NCH; k++) chk(wid(k) == w[k], tag, wid(k), w[k]);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    for (int k = 0; k < NCH; k++) chk(wid(k) == 0, "R1 width after reset", wid(k), 0);
    chk(wr_stb == 1'b0, "R1 strobe after reset", wr_stb, 0);
    chk(frame_done == 1'b0, "R1 done after reset", frame_done, 0);
    chk(state_probe == 3'd0, "R1 probe after reset", state_probe, 0);
  endtask

  task automatic t_no_start();
    int w [NCH] = '{40, 50, 60, 70, 80, 90};
    clear_mon();
    frame(600, w);
    chk(stb_n == 0, "R7 no strobe while parked", stb_n, 0);
    chk(state_probe == 3'd0, "R7 still parked", state_probe, 0);
    chk(wid(2) == 0, "R7 register untouched", wid(2), 0);
  endtask

  task automatic t_basic();
    int w [NCH] = '{30, 45, 60, 75, 90, 105};
    clear_mon();
    drive(1'b0, GAP);
    arm();
    chk(state_probe == 3'd1, "R10 probe seeking", state_probe, 1);
    drive(1'b1, 100);
    chk(state_probe == 3'd2, "R10 probe timing idle", state_probe, 2);
    drive(1'b1, IDLE - 100);
    for (int k = 0; k < NCH; k++) begin drive(1'b0, GAP); drive(1'b1, w[k]); end
    drive(1'b0, GAP); drive(1'b1, 20);
    check_widths("R4 basic width (idle exactly at threshold, R2)", w);
    chk(stb_n == NCH, "R5 strobe count", stb_n, NCH);
    chk(seq_bad == 0, "R5 index order", seq_bad, 0);
    chk(done_n == 1, "R6 one done pulse", done_n, 1);
    chk(state_probe == 3'd0, "R8 parked after frame", state_probe, 0);
  endtask

  task automatic t_short_idle();
    int w [NCH] = '{33, 44, 55, 66, 77, 88};
    clear_mon();
    drive(1'b0, GAP);
    arm();
    drive(1'b1, IDLE - 1);
    for (int k = 0; k < NCH; k++) begin drive(1'b0, GAP); drive(1'b1, 25); end
    chk(stb_n == 0, "R2 short idle rejected", stb_n, 0);
    frame(520, w);
    check_widths("R2 width after re-lock", w);
    chk(done_n == 1, "R2 one frame after re-lock", done_n, 1);
  endtask

  task automatic t_glitch();
    int w [NCH] = '{50, 50, 60, 50, 50, 50};
    clear_mon();
    drive(1'b0, GAP);
    arm();
    drive(1'b1, 600);
    drive(1'b0, GAP); drive(1'b1, 50);
    drive(1'b0, 5); drive(1'b1, STABLE - 1); drive(1'b0, 5); drive(1'b1, 50);
    drive(1'b0, GAP); drive(1'b1, 30); drive(1'b0, STABLE - 1); drive(1'b1, 27);
    for (int k = 3; k < NCH; k++) begin drive(1'b0, GAP); drive(1'b1, 50); end
    drive(1'b0, GAP); drive(1'b1, 20);
    check_widths("R3 glitch-filtered width", w);
    chk(stb_n == NCH, "R3 no extra channel from glitch", stb_n, NCH);
  endtask

  task automatic t_saturate();
    int w [NCH] = '{40, 40, 1100, 40, 40, 40};
    clear_mon();
    drive(1'b0, GAP);
    arm();
    frame(600, w);
    chk(wid(2) == MAXW, "R9 saturated width", wid(2), MAXW);
    chk(wid(3) == 40, "R9 next channel intact", wid(3), 40);
  endtask

  task automatic t_restart();
    int a [NCH] = '{31, 32, 33, 34, 35, 36};
    int b [NCH] = '{61, 62, 63, 64, 65, 66};
    clear_mon();
    drive(1'b0, GAP);
    @(negedge clk); start = 1'b1;
    frame(600, a);
    check_widths("R8 first frame", a);
    frame(600, b);
    check_widths("R8 second frame overwrites", b);
    chk(done_n == 2, "R8 two done pulses", done_n, 2);
    chk(seq_bad == 0, "R5 index order across frames", seq_bad, 0);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_start();
    t_basic();
    t_short_idle();
    t_glitch();
    t_saturate();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule